// File: doc/BRIEF.md
# Full-Page Burst Column Generator

This block generates the column address for one bank of a synchronous DRAM model when the burst length is programmed to full page. A READ or WRITE command loads a start column. The block then steps the column once per clock through a 256-column page. When the step passes the last column it wraps back to the start column and keeps going. The burst has no natural end: only a BURST STOP or a PRECHARGE command terminates it. While the burst runs, the block drives a write strobe for the storage array. For a write, the stop takes effect with zero cycles of delay, so the data presented on the cycle of the stop command is not stored.

Commands, the start column and all outputs are plain control pins, sampled or driven once per clock. No data streams cross this boundary, so there is no valid/ready pair and no back-pressure. The command, the start column and the command-type gating reach the outputs combinationally in the same cycle. The counter and the burst state are registered.

Top module: `fpb_col_gen`

## Requirements
- R1: After reset, with a NOP command (code 0) present, `burst_active` and `wr_en` are both 0.
- R2: On the cycle a READ (code 1) or WRITE (code 2) command is presented, `col_addr` equals `start_col` and `burst_active` is 1. `wr_en` is 1 for WRITE and 0 for READ.
- R3: On each later cycle of an active burst that carries NOP, `col_addr` is the previous column plus one, modulo 256.
- R4: The beat 256 cycles after the command returns `col_addr` to the start column. Counting continues from there (start+1, start+2, ...) for as long as no stop arrives, whatever the start column.
- R5: On the cycle BURST STOP (code 3) is presented, `burst_active` and `wr_en` are 0, so the data of that cycle is not written. The block then stays idle under NOP.
- R6: PRECHARGE (code 4) during a burst ends it exactly as BURST STOP does, on the same cycle.
- R7: A READ or WRITE that arrives during an active burst reloads the column from the new `start_col` and restarts the count. The burst takes the new command's type.
- R8: While idle, NOP, unused codes (5 to 7), BURST STOP and PRECHARGE leave `burst_active` and `wr_en` at 0.
- R9: A read burst never asserts `wr_en` on any of its beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd | input | 3 | Command: 0 NOP, 1 READ, 2 WRITE, 3 BURST STOP, 4 PRECHARGE, 5-7 treated as NOP |
| start_col | input | 8 | Start column, sampled with READ or WRITE |
| col_addr | output | 8 | Column addressed on this cycle |
| wr_en | output | 1 | Store the write data of this cycle at `col_addr` |
| burst_active | output | 1 | A burst beat occupies this cycle |

## Verification
Every one of the 256 start columns is driven through a write burst of more than 256 beats. This separates a counter that wraps to the start column from one that wraps to column zero or stops after one page. Read bursts with a spread of start columns are ended alternately by BURST STOP and PRECHARGE after varying lengths. These show that each stop command acts on its own cycle and that reads never strobe writes. Reloads during a burst, with the command type switched both ways, and stop or unused codes sent while idle separate a true restart from a counter that keeps running or ignores the new type.

// File: rtl/fpb_pkg.sv
package fpb_pkg;
  localparam int FPB_CMD_W = 3;

  typedef enum logic [FPB_CMD_W-1:0] {
    FPB_NOP   = 3'd0,
    FPB_READ  = 3'd1,
    FPB_WRITE = 3'd2,
    FPB_BSTOP = 3'd3,
    FPB_PRE   = 3'd4
  } fpb_cmd_e;
endpackage

// File: rtl/fpb_cmd_decode.sv
module fpb_cmd_decode
  import fpb_pkg::*;
(
  input  logic [FPB_CMD_W-1:0] cmd,
  output logic                 load,
  output logic                 load_wr,
  output logic                 stop
);
  always_comb begin
    load    = 1'b0;
    load_wr = 1'b0;
    stop    = 1'b0;
    case (cmd)
      FPB_READ:  load = 1'b1;
      FPB_WRITE: begin load = 1'b1; load_wr = 1'b1; end
      FPB_BSTOP: stop = 1'b1;
      FPB_PRE:   stop = 1'b1;
      default:   ;
    endcase
  end
endmodule

// File: rtl/fpb_col_counter.sv
module fpb_col_counter #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             advance,
  input  logic [COL_W-1:0] start_col,
  output logic [COL_W-1:0] col_cur
);
  localparam logic [COL_W-1:0] ONE = COL_W'(1);

  logic [COL_W-1:0] col_q;

  // The column of this cycle comes straight from the start pin when a command loads.
  assign col_cur = load ? start_col : col_q;

  // Natural overflow of the COL_W-bit field gives the page wrap.
  always_ff @(posedge clk) begin
    if (!rst_n)       col_q <= '0;
    else if (advance) col_q <= col_cur + ONE;
  end
endmodule

// File: rtl/fpb_burst_ctrl.sv
module fpb_burst_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic load_wr,
  input  logic stop,
  output logic active_cur,
  output logic wr_en
);
  logic active_q;
  logic wr_q;

  // A stop cancels the beat of its own cycle: zero-cycle termination.
  assign active_cur = load | (active_q & ~stop);
  assign wr_en      = load ? load_wr : (active_q & wr_q & ~stop);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      wr_q     <= 1'b0;
    end else begin
      active_q <= active_cur;
      if (load) wr_q <= load_wr;
    end
  end
endmodule

// File: rtl/fpb_col_gen.sv
module fpb_col_gen #(
  parameter int COL_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [fpb_pkg::FPB_CMD_W-1:0] cmd,
  input  logic [COL_W-1:0]              start_col,
  output logic [COL_W-1:0]              col_addr,
  output logic                          wr_en,
  output logic                          burst_active
);
  logic load, load_wr, stop, active_cur;

  fpb_cmd_decode u_dec (
    .cmd     (cmd),
    .load    (load),
    .load_wr (load_wr),
    .stop    (stop)
  );

  fpb_burst_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .load_wr    (load_wr),
    .stop       (stop),
    .active_cur (active_cur),
    .wr_en      (wr_en)
  );

  fpb_col_counter #(.COL_W(COL_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .advance   (active_cur),
    .start_col (start_col),
    .col_cur   (col_addr)
  );

  assign burst_active = active_cur;
endmodule

// File: rtl/fpb_col_gen_chk.sv
module fpb_col_gen_chk #(
  parameter int COL_W = 8
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [fpb_pkg::FPB_CMD_W-1:0] cmd,
  input logic [COL_W-1:0]              start_col,
  input logic [COL_W-1:0]              col_addr,
  input logic                          wr_en,
  input logic                          burst_active
);
  import fpb_pkg::*;

  logic             c_load, c_stop, c_is_wr;
  logic [COL_W-1:0] c_base, c_off;
  logic             c_last_wr;

  assign c_load  = (cmd == FPB_READ) || (cmd == FPB_WRITE);
  assign c_stop  = (cmd == FPB_BSTOP) || (cmd == FPB_PRE);
  assign c_is_wr = (cmd == FPB_WRITE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_base    <= '0;
      c_off     <= '0;
      c_last_wr <= 1'b0;
    end else if (c_load) begin
      c_base    <= start_col;
      c_off     <= COL_W'(1);
      c_last_wr <= c_is_wr;
    end else if (burst_active) begin
      c_off <= c_off + COL_W'(1);
    end
  end

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    c_load |-> (burst_active && col_addr == start_col && wr_en == c_is_wr));

  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_active && !c_load) |-> (col_addr == c_base + c_off));

  assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_active && !c_load && c_off == '0) |-> (col_addr == c_base));

  assert_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == FPB_BSTOP) |-> (!burst_active && !wr_en));

  assert_pre_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == FPB_PRE) |-> (!burst_active && !wr_en));

  assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !burst_active |=> (burst_active == c_load));

  assert_no_rd_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (c_is_wr || (!c_load && !c_stop && c_last_wr)));
endmodule

bind fpb_col_gen fpb_col_gen_chk #(.COL_W(COL_W)) u_chk (.*);

// File: tb/fpb_col_gen_bench.sv
module fpb_col_gen_bench;
  import fpb_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] cmd = 3'd0;
  logic [7:0] start_col = 8'd0;
  logic [7:0] col_addr;
  logic       wr_en, burst_active;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // bench reference state
  bit m_act = 1'b0;
  bit m_wr  = 1'b0;
  int m_base = 0;
  int m_k = 0;

  always #10 clk = ~clk;

  fpb_col_gen u_fpb_col_gen (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .start_col(start_col),
    .col_addr(col_addr), .wr_en(wr_en), .burst_active(burst_active)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic apply(input logic [2:0] c, input logic [7:0] s);
    bit e_act, e_wr;
    int e_col;
    string tag;
    @(negedge clk);
    cmd = c;
    start_col = s;
    #2;
    e_col = 0;
    if (c == FPB_READ || c == FPB_WRITE) begin
      tag = m_act ? "R7" : "R2";
      e_act = 1; e_wr = (c == FPB_WRITE); e_col = s;
      m_act = 1; m_wr = e_wr; m_base = s; m_k = 1;
    end else if (c == FPB_BSTOP || c == FPB_PRE) begin
      tag = !m_act ? "R8" : (c == FPB_BSTOP ? "R5" : "R6");
      e_act = 0; e_wr = 0; m_act = 0;
    end else if (m_act) begin
      tag = (m_k >= 256) ? "R4" : "R3";
      e_act = 1; e_wr = m_wr; e_col = (m_base + m_k) % 256;
      m_k++;
    end else begin
      tag = "R8";
      e_act = 0; e_wr = 0;
    end
    if (e_act && !e_wr) tag = {tag, "/R9"};
    chk(tag, "burst_active", int'(burst_active), int'(e_act));
    chk(tag, "wr_en", int'(wr_en), int'(e_wr));
    if (e_act) chk(tag, "col_addr", int'(col_addr), e_col);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 190000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1: reset state
    #2;
    chk("R1", "burst_active", int'(burst_active), 0);
    chk("R1", "wr_en", int'(wr_en), 0);
    // R8: idle with stops and unused codes
    apply(3'(FPB_BSTOP), 8'd0);
    apply(3'(FPB_PRE), 8'd9);
    for (int u = 5; u < 8; u++) apply(3'(u), 8'd3);
    // R2/R3/R4/R5: every start column, write burst beyond one page
    for (int s = 0; s < 256; s++) begin
      apply(3'(FPB_WRITE), 8'(s));
      for (int k = 0; k < 258 + (s % 5); k++) apply(3'(FPB_NOP), 8'(255 - s));
      apply(3'(FPB_BSTOP), 8'(s));
      apply(3'(FPB_NOP), 8'd0);
    end
    // R9/R5/R6: read bursts ended by each stop type after varying lengths
    for (int s = 1; s < 256; s += 17) begin
      apply(3'(FPB_READ), 8'(s));
      for (int k = 0; k < s + 3; k++) apply(3'(FPB_NOP), 8'(s + 1));
      apply((s % 2 == 1) ? 3'(FPB_PRE) : 3'(FPB_BSTOP), 8'd0);
      apply(3'(FPB_NOP), 8'd0);
    end
    // R7: reload mid burst, type switches both ways
    apply(3'(FPB_WRITE), 8'd250);
    for (int k = 0; k < 10; k++) apply(3'(FPB_NOP), 8'd0);
    apply(3'(FPB_READ), 8'd17);
    for (int k = 0; k < 5; k++) apply(3'(FPB_NOP), 8'd0);
    apply(3'(FPB_WRITE), 8'd255);
    for (int k = 0; k < 260; k++) apply(3'(FPB_NOP), 8'd0);
    apply(3'(FPB_WRITE), 8'd4);
    apply(3'(FPB_PRE), 8'd0);
    apply(3'(FPB_NOP), 8'd0);
    finish_run();
  end
endmodule